// File: doc/BRIEF.md
# Oversampled Serial Receiver with Masked Address Filter

This block recovers asynchronous serial frames from a single line that idles high. It samples the line on a 16x bit-rate tick enable. It supports two frame shapes: eight data bits, or eight data bits plus a ninth bit. The start edge restarts the sample counter, so bit centres line up with the incoming frame whatever the phase of the tick. Each bit is decided by a three-sample vote in the middle of the bit.

For multi-drop links the receiver can filter frames, so that a node is told only about frames that concern it. In the nine-bit shape, a frame whose ninth bit is 1 carries an address. That address is compared with the node's own address under a mask, and a broadcast form of the address is also accepted. In the eight-bit shape, the filter enable instead requires a valid stop bit. A framing-error pulse is given for every frame whose stop bit samples low, whether or not the frame is accepted.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rx_byte` and `rx_bit9` are 0, `rx_done` and `rx_ferr` are low, and the receiver is idle.
- R2: While idle, a frame starts on a tick where the synchronised line is 0 and was 1 on the previous tick. That tick is sample 0 and restarts the 16-count, so the bits are sampled at their centres for any phase of the start edge.
- R3: Each bit takes the majority of samples 7, 8 and 9 of its 16 samples, so a glitch one tick wide does not change a bit.
- R4: If the start bit votes 1, it is rejected as noise. The receiver returns to idle with no pulse on either flag and receives the next frame normally.
- R5: Data bits arrive LSB first. With `nine_bit`=0 the frame is start, 8 data, stop, and `rx_bit9` takes the stop-bit level. With `nine_bit`=1 the frame is start, 8 data, ninth bit, stop, and `rx_bit9` takes the ninth bit.
- R6: At the stop-bit vote tick, an accepted frame gives a one-clock `rx_done` pulse and updates `rx_byte` and `rx_bit9` in that same clock. `rx_byte` and `rx_bit9` change at no other time.
- R7: `rx_ferr` pulses for one clock at the stop-bit vote when the stop bit votes 0. This happens in both modes and whether or not the frame is accepted.
- R8: With `nine_bit`=0 and `filter_en`=1, a frame is accepted only if its stop bit votes 1. With `filter_en`=0 every frame is accepted.
- R9: With `nine_bit`=1 and `filter_en`=1, a frame is accepted only if its ninth bit is 1 and its data matches an address. One accepted address is the node's own: every bit where `addr_mask` is 1 must equal `own_addr`, and the other bits are ignored.
- R10: In the same mode, a broadcast address is also accepted. Every bit set in (`own_addr` | `addr_mask`) must be 1 in the data byte, and the other bits are ignored.
- R11: With `addr_mask` = 0, every frame with the ninth bit 1 is accepted, so address filtering is effectively off.
- R12: The receiver re-arms at the stop-bit vote. A new start edge that arrives after that point but before the nominal end of the stop bit is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idles high |
| tick16 | input | 1 | One-clock enable at 16x the bit rate |
| nine_bit | input | 1 | 1 selects the frame with a ninth bit |
| filter_en | input | 1 | Enables stop-bit or address qualification |
| own_addr | input | 8 | Node address |
| addr_mask | input | 8 | Address mask, 1 = bit compared |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit, or the stop level in 8-bit frames |
| rx_done | output | 1 | One-clock pulse per accepted frame |
| rx_ferr | output | 1 | One-clock pulse when the stop bit is low |

## Verification
Suppose the sample counter or the bit index goes wrong inside a frame. It would show up by the end of that same frame, as a byte shifted by one position, a missing or doubled `rx_done`, or a spurious `rx_ferr`. A fault in the filter terms appears on the first address frame whose acceptance depends on the faulty term. Because the outputs must hold when a frame is rejected, a wrong accept decision becomes visible as a changed `rx_byte`. A receiver that fails to return to idle shows up on the next frame, which is then lost.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int DATA_W = 8,
  parameter int OVS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              tick16,
  input  logic              nine_bit,
  input  logic              filter_en,
  input  logic [DATA_W-1:0] own_addr,
  input  logic [DATA_W-1:0] addr_mask,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_bit9,
  output logic              rx_done,
  output logic              rx_ferr
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W + 3);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] S_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] S_MID = CW'(MID);
  localparam logic [CW-1:0] S_HI  = CW'(MID + 1);
  localparam logic [CW-1:0] S_TOP = CW'(OVS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line, prev_q, busy_q, s_a, s_b, b9_q;
  logic [CW-1:0]          cnt_q;
  logic [IW-1:0]          idx_q, last_idx;
  logic [DATA_W-1:0]      sh_q, bcast;
  logic                   vote, at_vote, is_stop, is_data, hit_own, hit_bc, accept;

  assign line     = sync_q[SYNC_STAGES-1];
  assign vote     = (s_a & s_b) | (s_a & line) | (s_b & line);
  assign last_idx = nine_bit ? IW'(DATA_W + 2) : IW'(DATA_W + 1);
  assign at_vote  = busy_q && tick16 && (cnt_q == S_HI);
  assign is_stop  = (idx_q == last_idx);
  assign is_data  = (idx_q != '0) && (idx_q <= IW'(DATA_W));
  assign bcast    = own_addr | addr_mask;
  assign hit_own  = ((sh_q ^ own_addr) & addr_mask) == '0;
  assign hit_bc   = (sh_q & bcast) == bcast;
  assign accept   = !filter_en || (nine_bit ? (b9_q && (hit_own || hit_bc)) : vote);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      if (tick16) prev_q <= line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      s_a    <= 1'b1;
      s_b    <= 1'b1;
      sh_q   <= '0;
      b9_q   <= 1'b0;
    end else if (!busy_q) begin
      if (tick16 && prev_q && !line) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
        idx_q  <= '0;
      end
    end else if (tick16) begin
      cnt_q <= (cnt_q == S_TOP) ? '0 : cnt_q + 1'b1;
      if (cnt_q == S_LO)  s_a <= line;
      if (cnt_q == S_MID) s_b <= line;
      if (cnt_q == S_HI) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == '0) begin
          if (vote) busy_q <= 1'b0;
        end else if (is_data) begin
          sh_q <= {vote, sh_q[DATA_W-1:1]};
        end else if (!is_stop) begin
          b9_q <= vote;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      rx_bit9 <= 1'b0;
      rx_done <= 1'b0;
      rx_ferr <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      rx_ferr <= 1'b0;
      if (at_vote && is_stop) begin
        rx_ferr <= !vote;
        if (accept) begin
          rx_done <= 1'b1;
          rx_byte <= sh_q;
          rx_bit9 <= nine_bit ? b9_q : vote;
        end
      end
    end
  end
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick16,
  input logic              nine_bit,
  input logic              filter_en,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_bit9,
  input logic              rx_done,
  input logic              rx_ferr
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  a_r6_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> ($stable(rx_byte) && $stable(rx_bit9)));

  a_r7_ferr_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |=> !rx_ferr);

  a_r8_stop_required: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !nine_bit && filter_en) |-> (!rx_ferr && rx_bit9));

  a_r9_addr_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && nine_bit && filter_en) |-> rx_bit9);

  a_r2_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done || rx_ferr) |-> $past(tick16));
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .nine_bit(nine_bit),
  .filter_en(filter_en), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
  .rx_done(rx_done), .rx_ferr(rx_ferr)
);

// File: tb/uart_addr_rx_test.sv
module uart_addr_rx_test;
  localparam int BIT = 64;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, nine_bit = 1'b0, filter_en = 1'b0;
  logic [7:0] own_addr = '0, addr_mask = '0;
  logic [1:0] tdiv = '0;
  logic tick16;
  logic [7:0] rx_byte;
  logic rx_bit9, rx_done, rx_ferr;
  int n_chk = 0, n_bad = 0, n_done = 0, n_fe = 0;
  logic [7:0] last_byte = '0;
  bit ended = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd3);

  uart_addr_rx uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .nine_bit(nine_bit),
    .filter_en(filter_en), .own_addr(own_addr), .addr_mask(addr_mask),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_ferr(rx_ferr)
  );

  always @(negedge clk) if (rst_n) begin
    if (rx_done) begin n_done++; last_byte = rx_byte; end
    if (rx_ferr) n_fe++;
  end

  // {nine, filter, own[8], mask[8], data[8], bit9, stop, exp_done, exp_ferr}
  localparam logic [29:0] VEC [12] = '{
    {1'b0,1'b0,8'h00,8'h00,8'hA5,1'b0,1'b1,1'b1,1'b0}, // R5 R8
    {1'b0,1'b0,8'h00,8'h00,8'h3C,1'b0,1'b0,1'b1,1'b1}, // R7 R8
    {1'b0,1'b1,8'h00,8'h00,8'h5A,1'b0,1'b0,1'b0,1'b1}, // R7 R8
    {1'b0,1'b1,8'h00,8'h00,8'hC3,1'b0,1'b1,1'b1,1'b0}, // R8
    {1'b1,1'b0,8'h00,8'h00,8'h12,1'b0,1'b1,1'b1,1'b0}, // R5
    {1'b1,1'b1,8'hC0,8'hFD,8'hC0,1'b1,1'b1,1'b1,1'b0}, // R9
    {1'b1,1'b1,8'hC0,8'hFD,8'hC2,1'b1,1'b1,1'b1,1'b0}, // R9 masked bit
    {1'b1,1'b1,8'hC0,8'hFD,8'hC1,1'b1,1'b1,1'b0,1'b0}, // R9 R10 miss
    {1'b1,1'b1,8'hC0,8'hFD,8'hFF,1'b1,1'b1,1'b1,1'b0}, // R10
    {1'b1,1'b1,8'hC0,8'hFD,8'hC0,1'b0,1'b1,1'b0,1'b0}, // R9 ninth bit 0
    {1'b1,1'b1,8'h55,8'h00,8'h9E,1'b1,1'b1,1'b1,1'b0}, // R11
    {1'b1,1'b1,8'hC0,8'hFD,8'hC0,1'b1,1'b0,1'b1,1'b1}  // R7 R9
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic nine, logic [7:0] d, logic b9, logic stop, int stop_len, int glitch_bit);
    logic [10:0] bits;
    int nb;
    bits = nine ? {stop, b9, d, 1'b0} : {1'b0, stop, d, 1'b0};
    nb = nine ? 11 : 10;
    for (int i = 0; i < nb; i++) begin
      rxd = bits[i];
      if (i == glitch_bit) begin
        repeat (30) @(negedge clk);
        rxd = ~bits[i];
        repeat (4) @(negedge clk);
        rxd = bits[i];
        repeat (BIT - 34) @(negedge clk);
      end else begin
        repeat ((i == nb - 1) ? stop_len : BIT) @(negedge clk);
      end
    end
    rxd = 1'b1;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int d0, f0;
    logic [7:0] eb;
    logic eb9;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rx_byte", rx_byte, 0);
    chk("R1 rx_bit9", rx_bit9, 0);
    chk("R1 rx_done", rx_done, 0);
    chk("R1 rx_ferr", rx_ferr, 0);
    eb = '0; eb9 = 1'b0;
    repeat (BIT) @(negedge clk);

    for (int v = 0; v < 12; v++) begin
      logic [29:0] t;
      t = VEC[v];
      nine_bit = t[29]; filter_en = t[28]; own_addr = t[27:20]; addr_mask = t[19:12];
      d0 = n_done; f0 = n_fe;
      repeat (v % 3 + 1) @(negedge clk);
      send(t[29], t[11:4], t[3], t[2], BIT, -1);
      repeat (BIT) @(negedge clk);
      if (t[1]) begin eb = t[11:4]; eb9 = t[29] ? t[3] : t[2]; end
      chk("R8 R9 R10 R11 accept count", n_done - d0, int'(t[1]));
      chk("R7 ferr count", n_fe - f0, int'(t[0]));
      chk("R2 R5 R6 rx_byte", rx_byte, eb);
      chk("R5 R6 rx_bit9", rx_bit9, eb9);
      if (!rxd) $display("unexpected line state");
    end

    nine_bit = 1'b0; filter_en = 1'b0;
    d0 = n_done; f0 = n_fe;
    rxd = 1'b0; repeat (16) @(negedge clk); rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk("R4 noise start no done", n_done - d0, 0);
    chk("R4 noise start no ferr", n_fe - f0, 0);
    send(1'b0, 8'h81, 1'b0, 1'b1, BIT, -1);
    repeat (BIT) @(negedge clk);
    chk("R4 next frame received", n_done - d0, 1);
    chk("R4 next frame byte", rx_byte, 8'h81);

    d0 = n_done;
    send(1'b0, 8'h00, 1'b0, 1'b1, BIT, 3);
    repeat (BIT) @(negedge clk);
    chk("R3 glitch count", n_done - d0, 1);
    chk("R3 glitch filtered", rx_byte, 8'h00);

    d0 = n_done;
    send(1'b0, 8'h6E, 1'b0, 1'b1, 48, -1);
    send(1'b0, 8'hB7, 1'b0, 1'b1, BIT, -1);
    repeat (BIT) @(negedge clk);
    chk("R12 two frames", n_done - d0, 2);
    chk("R12 second byte", rx_byte, 8'hB7);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset clears byte", rx_byte, 0);
    summary();
  end
endmodule